// File: doc/BRIEF.md
# Bus-Master Disk DMA Controller

This block is a two-channel bus-master DMA engine for a disk drive interface. Software sees it through a small I/O register window. Each channel has a command byte, a status byte and a 32-bit pointer to a table of transfer descriptors in system memory. After software sets the start bit, the engine reads descriptors one at a time through a single memory port. It then moves 32-bit words between the buffers those descriptors name and the drive data port. It stops after the entry that carries the end-of-table flag.

The engine is shared by both channels, so only one channel can move data at a time, and status bit 7 always reports this. Completion is signalled by the drive. An edge on the drive's interrupt line sets the channel's interrupt flag. Software treats a transfer as good when the three low status bits read binary 100: interrupt set, error clear, not active. The register window for channel 1 begins eight bytes above the one for channel 0.

Top module: `bm_ide_dma`

## Requirements
- R1: `io_addr[3]` selects the channel and `io_addr[2:0]` selects the register: 0 is command, 2 is status, 4 is the table pointer. Reads at other offsets return 0. The pointer reads back with bits 1:0 forced to 0. The command byte reads back bit 0 (start) and bit 3 (direction); every other command bit reads 0.
- R2: Status bit 0 is active and read-only, bit 1 is error and bit 2 is interrupt. Bits 5 and 6 are plain read/write flags marking drive 0 and drive 1 as capable. Bits 3 and 4 read 0. Bit 7 always reads 1.
- R3: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 to either leaves it unchanged.
- R4: When the start bit changes from 0 to 1 while the engine is idle, the channel becomes active and the engine walks the table in order. Each entry is two words. The word at the entry address is the buffer address. The word at entry+4 holds the byte count in bits 15:0 and the end-of-table flag in bit 31.
- R5: Counts are whole words. Count bits 1:0 and buffer address bits 1:0 are ignored, and a count field of 0 means 65536 bytes.
- R6: Command bit 3 = 1 moves drive data into memory through memory writes. Bit 3 = 0 reads memory and presents the words on the drive write port.
- R7: After the last word of the entry with bit 31 set, active clears and no further fetch occurs. After the drive interrupt, the three low status bits read 100.
- R8: Clearing the start bit during a transfer ends it. Any memory access already issued is allowed to complete, then active clears and no further memory or drive handshakes occur.
- R9: A memory access that returns `mem_err` with its acknowledge sets the error bit of the running channel and clears active.
- R10: A rising edge on `drv_intrq[c]` sets interrupt bit c. `irq[c]` mirrors that bit.
- R11: Writing the command register with bit 0 set while the start bit is already 1 changes nothing: neither the readback nor the direction of the running transfer.
- R12: Setting the start bit of a channel while the engine serves the other channel is ignored, and the start bit reads back 0.
- R13: Once raised, `mem_req` stays high with unchanged `mem_addr` and `mem_we` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Register byte offset; bit 3 selects the channel |
| io_wr | input | 1 | Register write strobe |
| io_wdata | input | 32 | Register write data |
| io_rdata | output | 32 | Register read data (combinational on io_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes |
| mem_err | input | 1 | Memory access failed (valid with mem_ack) |
| mem_rdata | input | 32 | Memory read data (valid with mem_ack) |
| drv_sel | output | 1 | Channel whose drive the engine serves |
| drv_rvalid | input | 1 | Drive offers a word |
| drv_rdata | input | 32 | Word from the drive |
| drv_rready | output | 1 | Engine accepts the offered drive word |
| drv_wvalid | output | 1 | Engine offers a word to the drive |
| drv_wdata | output | 32 | Word to the drive |
| drv_wready | input | 1 | Drive accepts the offered word |
| drv_intrq | input | 2 | Drive interrupt line per channel |
| irq | output | 2 | Interrupt flag per channel |

## Verification
Several rules are checked by properties on every cycle: the request hold on the memory port, the end of a transfer after a fault, a stop or the last entry, the interrupt flag following a drive edge, and a refused start on the idle channel while the other one runs. The bench scenarios are needed to show the content side of the block. That covers the descriptor order, the word counts including the 65536-byte case, which buffer words reach the drive or memory, the status encodings and the write-one-to-clear behaviour at the register window.

// File: rtl/bm_ide_dma.sv
module bm_ide_dma (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  io_addr,
  input  logic        io_wr,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        drv_sel,
  input  logic        drv_rvalid,
  input  logic [31:0] drv_rdata,
  output logic        drv_rready,
  output logic        drv_wvalid,
  output logic [31:0] drv_wdata,
  input  logic        drv_wready,
  input  logic [1:0]  drv_intrq,
  output logic [1:0]  irq
);
  localparam int NCH  = 2;
  localparam int CNTW = 14;
  localparam int ENTB = 8;

  typedef enum logic [2:0] {S_IDLE, S_DADDR, S_DCNT, S_MRD, S_DOUT, S_DIN, S_MWR} state_t;

  state_t            state;
  logic              own, xdir, eot, waiting;
  logic [31:0]       cur_ptr, buf_addr, dbuf;
  logic [CNTW-1:0]   rem;
  logic [NCH-1:0]    run, dir, err, irq_st, cap0, cap1, intrq_q, act;
  logic [31:0]       tbl [NCH];
  state_t            nxt_ws;

  wire wch     = io_addr[3];
  wire cmd_wr  = io_wr && io_addr[2:0] == 3'd0;
  wire st_wr   = io_wr && io_addr[2:0] == 3'd2;
  wire ptr_wr  = io_wr && io_addr[2:0] == 3'd4;
  wire busy    = state != S_IDLE;
  wire halt    = !run[own];
  wire req_st  = state inside {S_DADDR, S_DCNT, S_MRD, S_MWR};
  wire start   = cmd_wr && io_wdata[0] && !run[wch] && !busy;
  wire last    = rem == '0;
  wire fault   = mem_req && mem_ack && mem_err;
  wire word_done = (state == S_DOUT && drv_wvalid && drv_wready) ||
                   (state == S_MWR && mem_req && mem_ack && !mem_err);

  assign mem_req    = req_st && (waiting || !halt);
  assign mem_we     = state == S_MWR;
  assign mem_addr   = (state == S_DADDR) ? cur_ptr :
                      (state == S_DCNT)  ? cur_ptr + 32'd4 : buf_addr;
  assign mem_wdata  = dbuf;
  assign drv_wvalid = state == S_DOUT && !halt;
  assign drv_rready = state == S_DIN && !halt;
  assign drv_wdata  = dbuf;
  assign drv_sel    = own;
  assign irq        = irq_st;
  assign act        = {busy && own, busy && !own};
  assign nxt_ws     = !last ? (xdir ? S_DIN : S_MRD) : (eot ? S_IDLE : S_DADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0; dir <= '0; err <= '0; irq_st <= '0;
      cap0 <= '0; cap1 <= '0; intrq_q <= '0;
      for (int c = 0; c < NCH; c++) tbl[c] <= '0;
    end else begin
      intrq_q <= drv_intrq;
      for (int c = 0; c < NCH; c++) begin
        if (wch == c[0]) begin
          if (cmd_wr && !(run[c] && io_wdata[0])) begin
            dir[c] <= io_wdata[3];
            run[c] <= io_wdata[0] && !busy;
          end
          if (ptr_wr) tbl[c] <= {io_wdata[31:2], 2'b00};
          if (st_wr) begin
            cap0[c] <= io_wdata[5];
            cap1[c] <= io_wdata[6];
          end
        end
        if (fault && own == c[0]) err[c] <= 1'b1;
        else if (st_wr && wch == c[0] && io_wdata[1]) err[c] <= 1'b0;
        if (drv_intrq[c] && !intrq_q[c]) irq_st[c] <= 1'b1;
        else if (st_wr && wch == c[0] && io_wdata[2]) irq_st[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; own <= 1'b0; xdir <= 1'b0; eot <= 1'b0; waiting <= 1'b0;
      cur_ptr <= '0; buf_addr <= '0; dbuf <= '0; rem <= '0;
    end else begin
      waiting <= mem_req && !mem_ack;
      case (state)
        S_IDLE:
          if (start) begin
            own     <= wch;
            xdir    <= io_wdata[3];
            cur_ptr <= tbl[wch];
            state   <= S_DADDR;
          end
        S_DOUT:
          if (halt) state <= S_IDLE;
          else if (drv_wready) state <= nxt_ws;
        S_DIN:
          if (halt) state <= S_IDLE;
          else if (drv_rvalid) begin
            dbuf  <= drv_rdata;
            state <= S_MWR;
          end
        default:
          if (!mem_req || fault) state <= S_IDLE;
          else if (mem_ack) begin
            case (state)
              S_DADDR: begin
                buf_addr <= {mem_rdata[31:2], 2'b00};
                state    <= S_DCNT;
              end
              S_DCNT: begin
                rem   <= mem_rdata[15:2] - 1'b1;
                eot   <= mem_rdata[31];
                state <= xdir ? S_DIN : S_MRD;
              end
              S_MRD: begin
                dbuf  <= mem_rdata;
                state <= S_DOUT;
              end
              default: state <= nxt_ws;
            endcase
          end
      endcase
      if (word_done) begin
        buf_addr <= buf_addr + 32'd4;
        rem      <= rem - 1'b1;
        if (last) cur_ptr <= cur_ptr + ENTB;
      end
    end
  end

  always_comb begin
    io_rdata = '0;
    case (io_addr[2:0])
      3'd0: io_rdata[7:0] = {4'b0000, dir[wch], 2'b00, run[wch]};
      3'd2: io_rdata[7:0] = {1'b1, cap1[wch], cap0[wch], 2'b00, irq_st[wch], err[wch], act[wch]};
      3'd4: io_rdata = tbl[wch];
      default: ;
    endcase
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_fault_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !busy && err != '0);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !run[own] && !mem_req |=> !busy);

  p_eot_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && last && eot |=> !busy);

  p_irq0_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drv_intrq[0] && !intrq_q[0] |=> irq[0]);

  p_irq1_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drv_intrq[1] && !intrq_q[1] |=> irq[1]);

  p_simplex_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && io_wdata[0] && busy && own != wch && !run[wch] |=> !run[$past(wch)]);

  p_dir_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(xdir));
endmodule

// File: tb/test_bm_ide_dma.sv
module test_bm_ide_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        drv_sel, drv_rready, drv_wvalid;
  logic [31:0] drv_rdata, drv_wdata;
  logic [1:0]  drv_intrq = '0;
  logic [1:0]  irq;

  int total = 0, fails = 0;
  int wcnt = 0, rcnt = 0, wl_n = 0, hold_bad = 0;
  logic [31:0] wv [3];
  logic [31:0] wlast = '0;
  logic [31:0] wl_a [8];
  logic [31:0] wl_d [8];
  logic        prev_pend = 1'b0, prev_we = 1'b0;
  logic [31:0] prev_addr = '0;

  always #10 clk = ~clk;

  assign drv_rdata = 32'hA000_0000 + 32'(rcnt);

  bm_ide_dma i_bm_ide_dma (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .drv_sel(drv_sel), .drv_rvalid(1'b1), .drv_rdata(drv_rdata), .drv_rready(drv_rready),
    .drv_wvalid(drv_wvalid), .drv_wdata(drv_wdata), .drv_wready(1'b1),
    .drv_intrq(drv_intrq), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'h5500_0000 ^ a;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h100: return 32'h0000_0200;
      32'h104: return 32'h0000_0008;
      32'h108: return 32'h0000_0302;
      32'h10C: return 32'h8000_0004;
      32'h180: return 32'h0000_0400;
      32'h184: return 32'h8000_000C;
      32'h1C0: return 32'h0001_0000;
      32'h1C4: return 32'h8000_0000;
      default: return pat(a);
    endcase
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_word(mem_addr);
      if (mem_addr[31:12] == 20'h00100) mem_err <= 1'b1;
      else if (mem_we) begin
        if (wl_n < 8) begin
          wl_a[wl_n] <= mem_addr;
          wl_d[wl_n] <= mem_wdata;
        end
        wl_n <= wl_n + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (drv_wvalid) begin
        if (wcnt < 3) wv[wcnt] <= drv_wdata;
        wlast <= drv_wdata;
        wcnt  <= wcnt + 1;
      end
      if (drv_rready) rcnt <= rcnt + 1;
      if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
        hold_bad <= hold_bad + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      prev_we   <= mem_we;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic io_w(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_r(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wr = 1'b0;
    #2 d = io_rdata;
  endtask

  task automatic wait_idle(input logic [3:0] st_a);
    logic [31:0] s;
    int n = 0;
    s = 32'h1;
    while (s[0] && n < 70000) begin
      io_r(st_a, s);
      n++;
    end
  endtask

  localparam logic [67:0] VEC [11] = '{
    {4'h4, 32'h1234_5677, 32'h1234_5674},
    {4'hC, 32'hCAFE_F00D, 32'hCAFE_F00C},
    {4'h0, 32'h0000_00F6, 32'h0000_0000},
    {4'h8, 32'h0000_00FE, 32'h0000_0008},
    {4'h2, 32'h0000_0060, 32'h0000_00E0},
    {4'hA, 32'h0000_0039, 32'h0000_00A0},
    {4'h2, 32'h0000_0000, 32'h0000_0080},
    {4'hA, 32'h0000_0000, 32'h0000_0080},
    {4'h0, 32'h0000_0008, 32'h0000_0008},
    {4'h0, 32'h0000_0000, 32'h0000_0000},
    {4'h8, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    io_r(4'h2, d); chk("R2 reset status ch0", d, 32'h80);
    io_r(4'hA, d); chk("R2 reset status ch1", d, 32'h80);
    io_r(4'h0, d); chk("R1 reset cmd ch0", d, 32'h0);
    io_r(4'hC, d); chk("R1 reset ptr ch1", d, 32'h0);
    io_r(4'h6, d); chk("R1 unmapped offset", d, 32'h0);
    chk("R10 reset irq", {30'b0, irq}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      io_w(VEC[i][67:64], VEC[i][63:32]);
      io_r(VEC[i][67:64], d);
      chk($sformatf("R1 R2 register vector %0d", i), d, VEC[i][31:0]);
    end

    io_w(4'h4, 32'h100);
    io_w(4'h0, 32'h01);
    wait_idle(4'h2);
    chk("R4 words sent", 32'(wcnt), 32'd3);
    chk("R4 first word", wv[0], pat(32'h200));
    chk("R4 second word", wv[1], pat(32'h204));
    chk("R5 address low bits ignored", wv[2], pat(32'h300));
    io_r(4'h2, d); chk("R7 before drive irq", d & 32'h7, 32'h0);
    @(negedge clk); drv_intrq = 2'b01;
    @(negedge clk); drv_intrq = 2'b00;
    io_r(4'h2, d); chk("R7 good status 100", d & 32'h7, 32'h4);
    chk("R10 irq output", {30'b0, irq}, 32'h1);
    io_w(4'h2, 32'h04);
    io_r(4'h2, d); chk("R3 irq cleared", d & 32'h7, 32'h0);
    chk("R10 irq output cleared", {30'b0, irq}, 32'h0);

    io_w(4'hC, 32'h180);
    io_w(4'h8, 32'h09);
    wait_idle(4'hA);
    chk("R6 memory writes", 32'(wl_n), 32'd3);
    chk("R6 write addr 0", wl_a[0], 32'h400);
    chk("R6 write data 0", wl_d[0], 32'hA000_0000);
    chk("R6 write addr 2", wl_a[2], 32'h408);
    chk("R6 write data 2", wl_d[2], 32'hA000_0002);
    chk("R6 no drive output", 32'(wcnt), 32'd3);

    io_w(4'h8, 32'h00);
    io_w(4'h0, 32'h00);
    io_w(4'h4, 32'h1C0);
    base = wcnt;
    io_w(4'h0, 32'h01);
    repeat (40) @(negedge clk);
    io_w(4'h8, 32'h01);
    io_r(4'h8, d); chk("R12 second start refused", d, 32'h0);
    io_r(4'hA, d); chk("R12 second not active", d & 32'h1, 32'h0);
    io_w(4'h0, 32'h09);
    io_r(4'h0, d); chk("R11 cmd unchanged", d, 32'h01);
    wait_idle(4'h2);
    chk("R5 zero count 65536 bytes", 32'(wcnt - base), 32'd16384);
    chk("R5 last word", wlast, pat(32'h1FFFC));
    chk("R11 direction kept", 32'(wl_n), 32'd3);

    io_w(4'h0, 32'h00);
    io_w(4'h0, 32'h01);
    repeat (30) @(negedge clk);
    io_w(4'h0, 32'h00);
    repeat (4) @(negedge clk);
    io_r(4'h2, d); chk("R8 stopped", d & 32'h1, 32'h0);
    base = wcnt;
    repeat (20) @(negedge clk);
    chk("R8 no more words", 32'(wcnt), 32'(base));
    chk("R8 no request", {31'b0, mem_req}, 32'h0);

    io_w(4'h4, 32'h0010_0FF0);
    io_w(4'h0, 32'h01);
    wait_idle(4'h2);
    io_r(4'h2, d); chk("R9 fault status", d & 32'h7, 32'h2);
    io_w(4'h2, 32'h00);
    io_r(4'h2, d); chk("R3 zero write keeps", d & 32'h7, 32'h2);
    io_w(4'h2, 32'h02);
    io_r(4'h2, d); chk("R3 error cleared", d & 32'h7, 32'h0);

    chk("R13 request hold", 32'(hold_bad), 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule